// File: doc/BRIEF.md
# Host Request Routing and Command Vector Unit

This unit sits on the host-bus side of a processor host port. The host programs a three-bit control register. Two of its bits gate the transmit-empty and receive-full status flags onto the host request pins. The third bit selects the pin routing. In merged routing, one pin carries the OR of both gated requests. In split routing, one pin carries the transmit request and a second pin carries the receive request. The status flags are inputs from the data path, which lies outside this unit. With both enables cleared, the host must poll.

The same host port also gives access to an 8-bit command register. Bit 7 is a command flag and bits 6:0 select one of 128 interrupt routines in the core. When the host sets the flag, the command is offered to the core as a pending request with its vector. The offer holds until the core returns a single-cycle acknowledge. The vector stays frozen while the command waits, so the core never samples a moving value. This command path is separate from the data path and has no effect on the request pins. A synchronous clear input models the software, individual and stop resets, and it empties the command register.

Host accesses are single-cycle register writes. A 1-bit select picks the register, with 0 for control and 1 for command. Reads are combinational on the same select. There is no back-pressure on the host side. On the core side, the command pending output acts as a valid signal and the acknowledge acts as a one-cycle accept.

Top module: `hrc_host_req_cmd`

## Requirements
- R1: After the active-low reset, both registers read 0, both request outputs are low and no command is pending.
- R2: The control register is written with select 0. Bit 0 enables receive requests, bit 1 enables transmit requests and bit 2 selects split routing. It reads back these three bits with all upper bits reading 0.
- R3: In merged routing (bit 2 = 0), req_main equals (tx enable AND tx_empty) OR (rx enable AND rx_full), and req_rx is low. Both outputs are registered and change one clock after their inputs change.
- R4: In split routing (bit 2 = 1), req_main equals tx enable AND tx_empty, and req_rx equals rx enable AND rx_full. Both outputs are registered and change one clock after their inputs change.
- R5: A cleared enable bit masks its status flag completely. Clearing an enable that was driving a request drops that request one clock later.
- R6: A write with select 1 while no command is pending stores all 8 bits. Bit 7 drives cmd_pending and bits 6:0 drive cmd_vector from the next cycle. The stored byte reads back as written.
- R7: A cycle of cmd_ack while a command is pending clears bit 7 and keeps the vector. cmd_ack while idle has no effect.
- R8: A command-register write while a command is pending is ignored entirely, and the vector stays stable.
- R9: A sw_clr pulse clears the whole command register in the next cycle and leaves the control register unchanged.
- R10: Posting or acknowledging a command has no effect on req_main or req_rx.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_clr | input | 1 | Synchronous clear of the command register |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | Register select: 0 control, 1 command |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data of the selected register |
| tx_empty | input | 1 | Transmit-empty status flag |
| rx_full | input | 1 | Receive-full status flag |
| req_main | output | 1 | Merged request, or transmit request in split routing |
| req_rx | output | 1 | Receive request in split routing, low otherwise |
| cmd_pending | output | 1 | Command offered to the core |
| cmd_vector | output | 7 | Interrupt vector of the command |
| cmd_ack | input | 1 | One-cycle acceptance from the core |

## Verification
The routing function is driven with all 32 combinations of routing mode, both enables and both status flags. This separates merged OR behaviour from split per-pin behaviour and shows that each enable masks only its own flag. Directed sequences then move one status flag or one enable at a time to confirm the single-cycle latency. The command path is exercised with a post, a write while pending, an acknowledge, an acknowledge while idle and a flag-clear post. These distinguish a frozen vector from one that tracks host writes. The request pins are held asserted during command traffic and sampled each cycle to show the two paths do not interact.

// File: rtl/hrc_pkg.sv
package hrc_pkg;
  localparam int unsigned CTRL_W    = 3;
  localparam int unsigned LANE_MAIN = 0;
  localparam int unsigned LANE_RX   = 1;
  localparam int unsigned NUM_LANES = 2;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_CMD  = 1'b1
  } hrc_sel_e;

  // bit 2: split routing, bit 1: tx enable, bit 0: rx enable
  typedef struct packed {
    logic split;
    logic tx_en;
    logic rx_en;
  } hrc_ctrl_t;
endpackage

// File: rtl/hrc_ctrl_reg.sv
module hrc_ctrl_reg
  import hrc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  hrc_ctrl_t wr_val,
  output hrc_ctrl_t ctrl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (wr_en)  ctrl_q <= wr_val;
  end
endmodule

// File: rtl/hrc_req_route.sv
module hrc_req_route
  import hrc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  hrc_ctrl_t            ctrl,
  input  logic                 tx_empty,
  input  logic                 rx_full,
  output logic [NUM_LANES-1:0] req_q
);
  logic                 tx_term;
  logic                 rx_term;
  logic [NUM_LANES-1:0] req_d;

  assign tx_term = ctrl.tx_en & tx_empty;
  assign rx_term = ctrl.rx_en & rx_full;

  always_comb begin
    req_d = '0;
    if (ctrl.split) begin
      req_d[LANE_MAIN] = tx_term;
      req_d[LANE_RX]   = rx_term;
    end else begin
      req_d[LANE_MAIN] = tx_term | rx_term;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/hrc_cmd_reg.sv
module hrc_cmd_reg #(
  parameter int unsigned VEC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_clr,
  input  logic             wr_en,
  input  logic [VEC_W:0]   wr_val,
  input  logic             ack,
  output logic             flag_q,
  output logic [VEC_W-1:0] vec_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      vec_q  <= '0;
    end else if (sw_clr) begin
      flag_q <= 1'b0;
      vec_q  <= '0;
    end else if (flag_q) begin
      // pending: host writes are locked out, only the core may retire it
      if (ack) flag_q <= 1'b0;
    end else if (wr_en) begin
      flag_q <= wr_val[VEC_W];
      vec_q  <= wr_val[VEC_W-1:0];
    end
  end
endmodule

// File: rtl/hrc_host_req_cmd.sv
module hrc_host_req_cmd
  import hrc_pkg::*;
#(
  parameter  int unsigned VEC_W = 7,
  localparam int unsigned REG_W = VEC_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_clr,
  input  logic             host_wr,
  input  logic             host_sel,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata,
  input  logic             tx_empty,
  input  logic             rx_full,
  output logic             req_main,
  output logic             req_rx,
  output logic             cmd_pending,
  output logic [VEC_W-1:0] cmd_vector,
  input  logic             cmd_ack
);
  hrc_ctrl_t            ctrl_q;
  logic                 ctrl_wr;
  logic                 cmd_wr;
  logic [NUM_LANES-1:0] req_q;

  assign ctrl_wr = host_wr && (host_sel == SEL_CTRL);
  assign cmd_wr  = host_wr && (host_sel == SEL_CMD);

  hrc_ctrl_reg u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ctrl_wr),
    .wr_val (hrc_ctrl_t'(host_wdata[CTRL_W-1:0])),
    .ctrl_q (ctrl_q)
  );

  hrc_req_route u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl_q),
    .tx_empty (tx_empty),
    .rx_full  (rx_full),
    .req_q    (req_q)
  );

  hrc_cmd_reg #(.VEC_W(VEC_W)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_clr (sw_clr),
    .wr_en  (cmd_wr),
    .wr_val (host_wdata),
    .ack    (cmd_ack),
    .flag_q (cmd_pending),
    .vec_q  (cmd_vector)
  );

  assign req_main = req_q[LANE_MAIN];
  assign req_rx   = req_q[LANE_RX];

  always_comb begin
    if (host_sel == SEL_CTRL) host_rdata = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
    else                      host_rdata = {cmd_pending, cmd_vector};
  end
endmodule

// File: rtl/hrc_chk.sv
module hrc_chk #(
  parameter int unsigned VEC_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_clr,
  input logic             host_wr,
  input logic             host_sel,
  input logic             tx_empty,
  input logic             rx_full,
  input logic             req_main,
  input logic             req_rx,
  input logic             cmd_pending,
  input logic [VEC_W-1:0] cmd_vector,
  input logic             cmd_ack,
  input logic [2:0]       ctrl_bits
);
  assert_merged_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctrl_bits[2]) |->
      (req_main == $past((ctrl_bits[1] & tx_empty) | (ctrl_bits[0] & rx_full))) && !req_rx);

  assert_split_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_bits[2]) |->
      (req_main == $past(ctrl_bits[1] & tx_empty)) && (req_rx == $past(ctrl_bits[0] & rx_full)));

  assert_ack_retires_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_ack && cmd_pending && !sw_clr) |-> !cmd_pending && (cmd_vector == $past(cmd_vector)));

  assert_locked_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_pending) && cmd_pending |-> $stable(cmd_vector));

  assert_locked_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_wr && host_sel && cmd_pending && !sw_clr) |-> cmd_vector == $past(cmd_vector));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_clr) |-> !cmd_pending && (cmd_vector == '0));
endmodule

bind hrc_host_req_cmd hrc_chk #(.VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sw_clr      (sw_clr),
  .host_wr     (host_wr),
  .host_sel    (host_sel),
  .tx_empty    (tx_empty),
  .rx_full     (rx_full),
  .req_main    (req_main),
  .req_rx      (req_rx),
  .cmd_pending (cmd_pending),
  .cmd_vector  (cmd_vector),
  .cmd_ack     (cmd_ack),
  .ctrl_bits   (ctrl_q)
);

// File: tb/hrc_host_req_cmd_bench.sv
`timescale 1ns/1ps
module hrc_host_req_cmd_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sw_clr = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_sel = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       tx_empty = 1'b0;
  logic       rx_full = 1'b0;
  logic       req_main, req_rx, cmd_pending, cmd_ack = 1'b0;
  logic [6:0] cmd_vector;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  hrc_host_req_cmd u_hrc_host_req_cmd (
    .clk(clk), .rst_n(rst_n), .sw_clr(sw_clr), .host_wr(host_wr),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_empty(tx_empty), .rx_full(rx_full), .req_main(req_main), .req_rx(req_rx),
    .cmd_pending(cmd_pending), .cmd_vector(cmd_vector), .cmd_ack(cmd_ack)
  );

  // {split, tx_en, rx_en, tx_empty, rx_full, exp req_main, exp req_rx}
  localparam logic [6:0] TBL [32] = '{
    7'b0_0000_00, 7'b0_0001_00, 7'b0_0010_00, 7'b0_0011_00,
    7'b0_0100_00, 7'b0_0101_10, 7'b0_0110_00, 7'b0_0111_10,
    7'b0_1000_00, 7'b0_1001_00, 7'b0_1010_10, 7'b0_1011_10,
    7'b0_1100_00, 7'b0_1101_10, 7'b0_1110_10, 7'b0_1111_10,
    7'b1_0000_00, 7'b1_0001_00, 7'b1_0010_00, 7'b1_0011_00,
    7'b1_0100_00, 7'b1_0101_01, 7'b1_0110_00, 7'b1_0111_01,
    7'b1_1000_00, 7'b1_1001_00, 7'b1_1010_10, 7'b1_1011_10,
    7'b1_1100_00, 7'b1_1101_01, 7'b1_1110_10, 7'b1_1111_11
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic sel, output logic [7:0] d);
    host_sel = sel;
    #0.5;
    d = host_rdata;
  endtask

  task automatic pulse_ack();
    @(negedge clk); cmd_ack = 1'b1;
    @(negedge clk); cmd_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    host_read(1'b0, rd); chk("R1 ctrl after reset", rd, 8'h00);
    host_read(1'b1, rd); chk("R1 cmd after reset", rd, 8'h00);
    chk("R1 requests low", {req_main, req_rx}, 2'b00);
    chk("R1 nothing pending", cmd_pending, 1'b0);
    rst_n = 1'b1;

    // R2 control readback
    host_write(1'b0, 8'hFF);
    host_read(1'b0, rd); chk("R2 upper bits read 0", rd, 8'h07);
    host_write(1'b0, 8'h05);
    host_read(1'b0, rd); chk("R2 readback 05", rd, 8'h05);

    // R3/R4 routing table, every combination
    for (int i = 0; i < 32; i++) begin
      logic [6:0] e;
      e = TBL[i];
      host_write(1'b0, {5'b0, e[6:4]});
      tx_empty = e[3]; rx_full = e[2];
      repeat (2) @(negedge clk);
      chk(e[6] ? "R4 split routing" : "R3 merged routing", {req_main, req_rx}, e[1:0]);
    end

    // R3 one-cycle latency on a status flag
    host_write(1'b0, 8'h02);
    tx_empty = 1'b0; rx_full = 1'b0;
    repeat (2) @(negedge clk);
    tx_empty = 1'b1;
    #0.5; chk("R3 not yet updated", req_main, 1'b0);
    @(negedge clk); chk("R3 updated after one clock", req_main, 1'b1);

    // R5 clearing the enable drops the request one clock later
    host_write(1'b0, 8'h00);
    chk("R5 still set before route register", req_main, 1'b1);
    @(negedge clk); chk("R5 masked by cleared enable", req_main, 1'b0);
    rx_full = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 rx flag masked", {req_main, req_rx}, 2'b00);

    // R6 post a command
    host_write(1'b1, 8'hAA);
    chk("R6 pending raised", cmd_pending, 1'b1);
    chk("R6 vector", cmd_vector, 7'h2A);
    host_read(1'b1, rd); chk("R6 readback", rd, 8'hAA);

    // R8 write while pending is ignored
    host_write(1'b1, 8'h15);
    chk("R8 vector unchanged", cmd_vector, 7'h2A);
    host_read(1'b1, rd); chk("R8 register unchanged", rd, 8'hAA);

    // R7 acknowledge
    pulse_ack();
    chk("R7 pending cleared", cmd_pending, 1'b0);
    chk("R7 vector kept", cmd_vector, 7'h2A);
    pulse_ack();
    host_read(1'b1, rd); chk("R7 idle ack no effect", rd, 8'h2A);

    // R6 write with flag clear stores vector only
    host_write(1'b1, 8'h33);
    chk("R6 flag-clear write", {cmd_pending, cmd_vector}, 8'h33);

    // R9 clear input
    host_write(1'b0, 8'h03);
    host_write(1'b1, 8'hFF);
    chk("R9 pending before clear", cmd_pending, 1'b1);
    @(negedge clk); sw_clr = 1'b1;
    @(negedge clk); sw_clr = 1'b0;
    host_read(1'b1, rd); chk("R9 command cleared", rd, 8'h00);
    host_read(1'b0, rd); chk("R9 control kept", rd, 8'h03);

    // R10 command traffic leaves requests alone
    host_write(1'b0, 8'h02);
    tx_empty = 1'b1; rx_full = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 request before command", {req_main, req_rx}, 2'b10);
    host_write(1'b1, 8'h81);
    chk("R10 request during post", {req_main, req_rx}, 2'b10);
    pulse_ack();
    chk("R10 request after ack", {req_main, req_rx}, 2'b10);
    chk("R10 command retired", cmd_pending, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule